// File: doc/BRIEF.md
# Indirect Codec Control Register Bridge

This block lets a host bus reach a small bank of 8-bit codec control registers through two 32-bit windows. A host write to the command window carries a write strobe, a 7-bit internal register address and a data byte. With the strobe set, the block starts an internal write that keeps a busy flag raised for a fixed number of cycles. With the strobe clear, the write only selects a register for reading.

The selected register appears in the low byte of the data window after a settling delay counted from the address update. The same window carries the codec interrupt request line in bit 8. Each register comes out of reset at its own default value. Register 0 is a read-only status byte that the codec supplies live. Addresses past the last register take no writes and read as zero.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, the command window reads 0x00000000 and internal registers 0..27 hold the defaults 00 FC 1B 20 00 80 00 00 FF 1F 3F 00 06 06 06 06 00 00 00 00 00 34 07 44 1F 00 00 00, in address order. Register 0 instead reads status_i.
- R2: The command window is at byte offset 0x00 and the data window is at 0x04. Every other offset reads 0, and host writes to other offsets have no effect.
- R3: A command write with bit 16 set starts a write of bits 7:0 to the register at bits 14:8. Command-window bit 16 then reads 1 for exactly WR_CYC (default 4) cycles and then returns to 0 on its own, and the register holds the new value.
- R4: A command write that arrives while bit 16 is 1 is dropped completely: neither the address nor any register changes.
- R5: A command write with bit 16 clear only selects the address in bits 14:8. It changes no register and does not set the busy bit.
- R6: Data-window bits 7:0 show the selected register from the SETTLE_CYC-th (default 6th) clock edge after the address update onward. Before that edge they keep their previous value.
- R7: Data-window bit 8 follows irq_i, and bits 31:9 read 0.
- R8: Address 0 reads the live status_i byte, and writes to address 0 are dropped.
- R9: Addresses 28..127 read 0, and writes to them change no register (no aliasing onto low addresses).
- R10: A command-window read returns the busy flag in bit 16 and the selected address in bits 14:8, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Host access strobe |
| bus_we_i | input | 1 | Host write enable |
| bus_addr_i | input | OFFS_W (4) | Byte offset of the window |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data (combinational) |
| status_i | input | 8 | Live codec status byte for register 0 |
| irq_i | input | 1 | Codec interrupt request line |

## Verification
A wrong busy counter shows up in the command window within WR_CYC+1 cycles, as a busy bit that is held too long, drops too early, or lets a second command through. A fault in the settle counter or the read pipeline shows on the data window at the sixth edge after a select, as either a stale byte or an early one. Wrong reset defaults, or address decoding that folds high addresses onto low ones, show on the first read-back of the affected register after a select.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;
  localparam int REG_W = 8;

  function automatic logic [REG_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      1:       return 8'hFC;
      2:       return 8'h1B;
      3:       return 8'h20;
      5:       return 8'h80;
      8:       return 8'hFF;
      9:       return 8'h1F;
      10:      return 8'h3F;
      12, 13, 14, 15: return 8'h06;
      21:      return 8'h34;
      22:      return 8'h07;
      23:      return 8'h44;
      24:      return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_bridge_pkg::*;
#(
  parameter int NUM_REGS = 28,
  parameter int AW       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [REG_W-1:0] status_i,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int IW = $clog2(NUM_REGS);

  logic [REG_W-1:0] regs [1:NUM_REGS-1];
  logic             rd_hit;

  // register 0 is not stored: it is the live status byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else begin
      for (int i = 1; i < NUM_REGS; i++)
        if (wr_en_i && wr_addr_i == AW'(i)) regs[i] <= wr_data_i;
    end
  end

  assign rd_hit = (rd_addr_i < AW'(NUM_REGS));

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0)  rd_data_o = status_i;
    else if (rd_hit)      rd_data_o = regs[rd_addr_i[IW-1:0]];
  end

  // R8/R9: a register moves only on a write aimed at its own address
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_chk
    a_r9_untouched_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == AW'(g)) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/codec_cmd_ctrl.sv
module codec_cmd_ctrl #(
  parameter int AW         = 7,
  parameter int WR_CYC     = 4,
  parameter int SETTLE_CYC = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          cmd_strobe_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [7:0]    cmd_data_i,
  output logic          busy_o,
  output logic [AW-1:0] sel_addr_o,
  output logic          commit_o,
  output logic [7:0]    wr_data_o,
  output logic          settled_o
);
  localparam int WCW = $clog2(WR_CYC + 1);
  localparam int SCW = $clog2(SETTLE_CYC + 1);

  logic           busy_q;
  logic [WCW-1:0] wcnt_q;
  logic [SCW-1:0] scnt_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     wdata_q;
  logic           accept;

  assign accept = cmd_we_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wcnt_q  <= '0;
      scnt_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q <= cmd_addr_i;
      scnt_q <= SCW'(SETTLE_CYC - 1);
      if (cmd_strobe_i) begin
        busy_q  <= 1'b1;
        wcnt_q  <= WCW'(WR_CYC - 1);
        wdata_q <= cmd_data_i;
      end
    end else begin
      if (scnt_q != '0) scnt_q <= scnt_q - 1'b1;
      if (busy_q) begin
        if (wcnt_q == '0) busy_q <= 1'b0;
        else              wcnt_q <= wcnt_q - 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign sel_addr_o = addr_q;
  assign commit_o   = busy_q && (wcnt_q == '0);
  assign wr_data_o  = wdata_q;
  assign settled_o  = (scnt_q == '0);

  a_r4_addr_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cmd_we_i |=> $stable(addr_q));
  a_r3_busy_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) && (WR_CYC > 1) |=> busy_q);
  a_r3_commit_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_q);
endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int NUM_REGS   = 28,
  parameter int WR_CYC     = 4,
  parameter int SETTLE_CYC = 6,
  parameter int OFFS_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [OFFS_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [7:0]        status_i,
  input  logic              irq_i
);
  localparam int AW = 7;

  logic             cmd_sel, dat_sel, cmd_we;
  logic             busy, commit, settled;
  logic [AW-1:0]    sel_addr;
  logic [7:0]       wr_data;
  logic [REG_W-1:0] bank_rd, data_q;
  logic             unused_wbits;

  assign cmd_sel      = (bus_addr_i == OFFS_W'(0));
  assign dat_sel      = (bus_addr_i == OFFS_W'(4));
  assign cmd_we       = bus_valid_i && bus_we_i && cmd_sel;
  assign unused_wbits = ^{bus_wdata_i[31:17], bus_wdata_i[15]};

  codec_cmd_ctrl #(.AW(AW), .WR_CYC(WR_CYC), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we),
    .cmd_strobe_i (bus_wdata_i[16]),
    .cmd_addr_i   (bus_wdata_i[14:8]),
    .cmd_data_i   (bus_wdata_i[7:0]),
    .busy_o       (busy),
    .sel_addr_o   (sel_addr),
    .commit_o     (commit),
    .wr_data_o    (wr_data),
    .settled_o    (settled)
  );

  codec_reg_bank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .wr_addr_i (sel_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (sel_addr),
    .status_i  (status_i),
    .rd_data_o (bank_rd)
  );

  // read byte is captured only once the select has settled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (settled) data_q <= bank_rd;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (cmd_sel) bus_rdata_o = {15'd0, busy, 1'b0, sel_addr, 8'd0};
    else if (dat_sel) bus_rdata_o = {23'd0, irq_i, data_q};
  end

  a_r6_hold_unsettled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settled |=> $stable(data_q));
  a_r9_high_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_addr >= AW'(NUM_REGS)) |-> (bank_rd == '0));
endmodule

// File: tb/sim_codec_reg_bridge.sv
`timescale 1ns/1ps
module sim_codec_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  status = 8'hA5;
  logic        irq = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v;

  localparam logic [31:0] WR = 32'h0001_0000;
  localparam logic [7:0] DEF [28] = '{
    8'h00, 8'hFC, 8'h1B, 8'h20, 8'h00, 8'h80, 8'h00, 8'h00,
    8'hFF, 8'h1F, 8'h3F, 8'h00, 8'h06, 8'h06, 8'h06, 8'h06,
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h34, 8'h07, 8'h44,
    8'h1F, 8'h00, 8'h00, 8'h00};

  always #2.5 clk = ~clk;

  codec_reg_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .status_i(status), .irq_i(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = off; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] off, output logic [31:0] d);
    addr = off;
    #1;
    d = rdata;
  endtask

  task automatic sel(input logic [6:0] a);
    bus_wr(4'h0, {16'd0, 1'b0, a, 8'd0});
    wait_n(6);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    bus_wr(4'h0, WR | {17'd0, a, d});
    wait_n(6);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    bus_rd(4'h0, v); chk("R1 cmd window after reset", v, 32'h0);

    // R1: default table walk
    for (int i = 0; i < 28; i++) begin
      sel(7'(i));
      bus_rd(4'h4, v);
      chk($sformatf("R1 default reg %0d", i), {24'd0, v[7:0]},
          {24'd0, (i == 0) ? status : DEF[i]});
    end

    // R10: command window format
    sel(7'h15);
    bus_rd(4'h0, v); chk("R10 cmd readback", v, 32'h0000_1500);

    // R3: busy length and write effect
    begin
      int n = 0;
      bus_wr(4'h0, WR | 32'h0000_053C);
      bus_rd(4'h0, v);
      while (v[16] && n < 20) begin n++; @(negedge clk); bus_rd(4'h0, v); end
      chk("R3 busy cycles", n, 4);
      wait_n(3);
      bus_rd(4'h4, v); chk("R3 written value", v[7:0], 8'h3C);
    end

    // R4: second command while busy dropped
    bus_wr(4'h0, WR | 32'h0000_0355);
    bus_wr(4'h0, WR | 32'h0000_0466);
    bus_rd(4'h0, v); chk("R4 addr kept while busy", v[14:8], 7'h03);
    wait_n(6);
    bus_rd(4'h4, v); chk("R4 first write landed", v[7:0], 8'h55);
    sel(7'h04);
    bus_rd(4'h4, v); chk("R4 dropped write reg4", v[7:0], 8'h00);

    // R5: select only
    bus_wr(4'h0, 32'h0000_06EE);
    bus_rd(4'h0, v); chk("R5 no busy on select", v, 32'h0000_0600);
    wait_n(6);
    bus_rd(4'h4, v); chk("R5 reg6 unchanged", v[7:0], 8'h00);

    // R6: settle edge
    sel(7'h01);
    bus_wr(4'h0, 32'h0000_0200);
    wait_n(5);
    bus_rd(4'h4, v); chk("R6 old value before settle", v[7:0], 8'hFC);
    wait_n(1);
    bus_rd(4'h4, v); chk("R6 new value at settle", v[7:0], 8'h1B);

    // R7: irq bit
    irq = 1'b1;
    bus_rd(4'h4, v); chk("R7 irq high", v, 32'h0000_011B);
    irq = 1'b0;
    bus_rd(4'h4, v); chk("R7 irq low", v, 32'h0000_001B);

    // R8: status register read-only, live
    wr_reg(7'h00, 8'h12);
    bus_rd(4'h4, v); chk("R8 write to status dropped", v[7:0], 8'hA5);
    status = 8'h5A;
    wait_n(2);
    bus_rd(4'h4, v); chk("R8 status live", v[7:0], 8'h5A);

    // R9: high addresses
    wr_reg(7'h62, 8'h77);
    bus_rd(4'h4, v); chk("R9 high addr reads 0", v[7:0], 8'h00);
    sel(7'h02);
    bus_rd(4'h4, v); chk("R9 no alias onto reg2", v[7:0], 8'h1B);
    sel(7'h1B);
    bus_rd(4'h4, v); chk("R9 last reg default", v[7:0], 8'h00);

    // R2: other offsets
    bus_wr(4'h8, WR | 32'h0000_0599);
    bus_rd(4'h0, v); chk("R2 write to 0x08 dropped", v, 32'h0000_1B00);
    wait_n(6);
    sel(7'h05);
    bus_rd(4'h4, v); chk("R2 reg5 unchanged", v[7:0], 8'h3C);
    bus_rd(4'hC, v); chk("R2 offset 0x0C reads 0", v, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule